// File: doc/BRIEF.md
# Two-Cycle Flash Command Decoder

This block is the command register state machine of a byte-wide flash interface. It receives write cycles that an earlier stage has already latched. Each cycle carries an address and a data byte. The block also receives a program-enable level that stands in for the high-voltage supply. It decodes those writes into one-cycle and two-cycle commands. It chooses whether reads return array data or identifier codes. It issues single-cycle program or erase start pulses, together with an address and a data byte, to a separate sequencer.

Program and erase are two-cycle commands: a setup byte, then a second write. For program, the second write carries the target address and the byte to store. For erase, the second write must repeat the erase code. A second cycle that does not match a pending erase setup drops that setup, and the decoder falls back to array read. The register is held in array read mode when the enable level is absent. Writes are also ignored while the sequencer reports busy.

Top module: `flashcmd_decoder`

## Requirements
- R1: After reset the decoder is in array read mode: `read_ident` = 0, `id_data` = 00h, both start pulses low, `start_addr` = 0, `start_data` = 00h.
- R2: An accepted write of 00h or FFh selects array read mode from any state that is not awaiting a second cycle. Two such writes in a row (the reset sequence) leave the decoder in array read mode.
- R3: An accepted write of 80h or 90h selects identifier mode, so that `read_ident` = 1 on the cycle after the write.
- R4: In identifier mode `id_data` is 01h when `id_addr_lsb` = 0 and 29h when it is 1. Every identifier code has an odd number of ones, with bit 7 acting as the parity bit. Outside identifier mode `id_data` is 00h.
- R5: An accepted write of 30h followed by a second accepted write of 30h raises `erase_start` for exactly one cycle, in the cycle after the second write.
- R6: An accepted write of 10h or 50h, followed by any accepted write, raises `prog_start` for one cycle. `start_addr` and `start_data` then hold that second write's address and data.
- R7: After an erase setup, an accepted second write whose byte is not 30h starts nothing and returns the decoder to array read mode.
- R8: While `prog_en` is low, the decoder is in array read mode and ignores every write. When `prog_en` returns, the decoder is still in array read mode.
- R9: Writes presented while `seq_busy` is high have no effect on the mode or on any output.
- R10: In array read or identifier mode, an accepted byte that is not a recognised command leaves the mode unchanged.
- R11: A start pulse leaves the decoder in array read mode, and program and erase never start in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_en | input | 1 | Program-enable level; low holds read mode |
| seq_busy | input | 1 | Sequencer busy; writes are ignored while high |
| wr_valid | input | 1 | A latched write cycle is present |
| wr_addr | input | ADDR_W | Address of the write cycle |
| wr_data | input | 8 | Data byte of the write cycle |
| id_addr_lsb | input | 1 | Low address bit of the current read |
| read_ident | output | 1 | Reads return identifier codes when high |
| id_data | output | 8 | Identifier byte for the current read |
| prog_start | output | 1 | One-cycle program request |
| erase_start | output | 1 | One-cycle erase request |
| start_addr | output | ADDR_W | Address belonging to the last start |
| start_data | output | 8 | Data belonging to the last start |

## Verification
A confirming second write can arrive in the same cycle that the enable level drops or that the sequencer reports busy. In that case the start must be suppressed: the first case also clears the pending setup, while the second keeps it. Directed sequences place an erase confirm exactly on a cycle with `prog_en` low, and another exactly on a cycle with `seq_busy` high. Each is judged by whether a later single 30h write starts an erase, which it must only in the busy case. Random stimulus also toggles both levels freely under a reference model.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

    typedef enum logic [1:0] {
        M_READ     = 2'd0,
        M_IDENT    = 2'd1,
        M_ERASE_SU = 2'd2,
        M_PROG_SU  = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        C_READ  = 3'd0,
        C_IDENT = 3'd1,
        C_ERASE = 3'd2,
        C_PROG  = 3'd3,
        C_OTHER = 3'd4
    } cmd_class_e;

endpackage

// File: rtl/flashcmd_classify.sv
module flashcmd_classify
    import flashcmd_pkg::*;
#(
    parameter logic [7:0] READ_A  = 8'h00,
    parameter logic [7:0] READ_B  = 8'hFF,
    parameter logic [7:0] IDENT_A = 8'h80,
    parameter logic [7:0] IDENT_B = 8'h90,
    parameter logic [7:0] ERASE_C = 8'h30,
    parameter logic [7:0] PROG_A  = 8'h10,
    parameter logic [7:0] PROG_B  = 8'h50
) (
    input  logic [7:0] byte_in,
    output cmd_class_e cls
);

    always_comb begin
        if (byte_in == READ_A || byte_in == READ_B)
            cls = C_READ;
        else if (byte_in == IDENT_A || byte_in == IDENT_B)
            cls = C_IDENT;
        else if (byte_in == ERASE_C)
            cls = C_ERASE;
        else if (byte_in == PROG_A || byte_in == PROG_B)
            cls = C_PROG;
        else
            cls = C_OTHER;
    end

endmodule

// File: rtl/flashcmd_idsrc.sv
module flashcmd_idsrc #(
    parameter logic [7:0] MFR_CODE    = 8'h01,
    parameter logic [7:0] DEV_CODE    = 8'h29,
    parameter bit         PARITY_FILL = 1'b1
) (
    input  logic       enable,
    input  logic       sel,
    output logic [7:0] code_out
);

    logic [7:0] raw;

    always_comb raw = sel ? DEV_CODE : MFR_CODE;

    generate
        if (PARITY_FILL) begin : g_parity
            // bit 7 chosen so the whole byte has an odd number of ones
            always_comb code_out = enable ? {~^raw[6:0], raw[6:0]} : 8'h00;
        end else begin : g_plain
            always_comb code_out = enable ? raw : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/flashcmd_decoder.sv
module flashcmd_decoder
    import flashcmd_pkg::*;
#(
    parameter int         ADDR_W   = 18,
    parameter logic [7:0] MFR_CODE = 8'h01,
    parameter logic [7:0] DEV_CODE = 8'h29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              seq_busy,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              id_addr_lsb,
    output logic              read_ident,
    output logic [7:0]        id_data,
    output logic              prog_start,
    output logic              erase_start,
    output logic [ADDR_W-1:0] start_addr,
    output logic [7:0]        start_data
);

    typedef struct packed {
        mode_e             mode;
        logic              prog_start;
        logic              erase_start;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } state_t;

    state_t     st_d, st_q;
    cmd_class_e cls;
    logic       accept;

    flashcmd_classify u_classify (
        .byte_in (wr_data),
        .cls     (cls)
    );

    flashcmd_idsrc #(
        .MFR_CODE    (MFR_CODE),
        .DEV_CODE    (DEV_CODE),
        .PARITY_FILL (1'b1)
    ) u_idsrc (
        .enable   (st_q.mode == M_IDENT),
        .sel      (id_addr_lsb),
        .code_out (id_data)
    );

    always_comb accept = wr_valid && prog_en && !seq_busy;

    always_comb begin
        st_d             = st_q;
        st_d.prog_start  = 1'b0;
        st_d.erase_start = 1'b0;
        if (!prog_en) begin
            st_d.mode = M_READ;
        end else if (accept) begin
            unique case (st_q.mode)
                M_PROG_SU: begin
                    st_d.prog_start = 1'b1;
                    st_d.addr       = wr_addr;
                    st_d.data       = wr_data;
                    st_d.mode       = M_READ;
                end
                M_ERASE_SU: begin
                    if (cls == C_ERASE) begin
                        st_d.erase_start = 1'b1;
                        st_d.addr        = wr_addr;
                        st_d.data        = wr_data;
                    end
                    st_d.mode = M_READ;
                end
                default: begin
                    case (cls)
                        C_READ:  st_d.mode = M_READ;
                        C_IDENT: st_d.mode = M_IDENT;
                        C_ERASE: st_d.mode = M_ERASE_SU;
                        C_PROG:  st_d.mode = M_PROG_SU;
                        default: st_d.mode = st_q.mode;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_READ, prog_start: 1'b0, erase_start: 1'b0,
                      addr: '0, data: 8'h00};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        read_ident  = (st_q.mode == M_IDENT);
        prog_start  = st_q.prog_start;
        erase_start = st_q.erase_start;
        start_addr  = st_q.addr;
        start_data  = st_q.data;
    end

endmodule

// File: rtl/flashcmd_decoder_chk.sv
module flashcmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prog_en,
    input logic       seq_busy,
    input logic       wr_valid,
    input logic [7:0] wr_data,
    input logic       read_ident,
    input logic [7:0] id_data,
    input logic       prog_start,
    input logic       erase_start
);

    assert_unpowered_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> (!prog_start && !erase_start && !read_ident));

    assert_busy_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> (!prog_start && !erase_start));

    assert_single_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, erase_start}));

    assert_start_in_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start || erase_start) |-> !read_ident);

    assert_erase_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> $past(wr_valid && wr_data == 8'h30));

    assert_id_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        read_ident |-> (($countones(id_data) % 2) == 1));

    assert_id_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !read_ident |-> (id_data == 8'h00));

endmodule

bind flashcmd_decoder flashcmd_decoder_chk u_chk (.*);

// File: tb/flashcmd_decoder_tb.sv
module flashcmd_decoder_tb;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_en = 1'b0;
    logic          seq_busy = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = 8'h00;
    logic          id_addr_lsb = 1'b0;
    logic          read_ident;
    logic [7:0]    id_data;
    logic          prog_start;
    logic          erase_start;
    logic [AW-1:0] start_addr;
    logic [7:0]    start_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model: 0 read, 1 ident, 2 erase setup, 3 program setup
    int            m_mode = 0;
    bit            m_ps = 0;
    bit            m_es = 0;
    logic [AW-1:0] m_addr = '0;
    logic [7:0]    m_data = 8'h00;

    always #2 clk = ~clk;

    flashcmd_decoder #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .seq_busy(seq_busy),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .id_addr_lsb(id_addr_lsb), .read_ident(read_ident), .id_data(id_data),
        .prog_start(prog_start), .erase_start(erase_start),
        .start_addr(start_addr), .start_data(start_data)
    );

    function automatic int classify(input logic [7:0] b);
        if (b == 8'h00 || b == 8'hFF) return 0;
        if (b == 8'h80 || b == 8'h90) return 1;
        if (b == 8'h30) return 2;
        if (b == 8'h10 || b == 8'h50) return 3;
        return 4;
    endfunction

    function automatic logic [7:0] exp_id(input int mode, input logic lsb);
        if (mode != 1) return 8'h00;
        return lsb ? 8'h29 : 8'h01;
    endfunction

    task automatic model_step();
        int c;
        m_ps = 0;
        m_es = 0;
        c = classify(wr_data);
        if (!prog_en) m_mode = 0;
        else if (wr_valid && !seq_busy) begin
            if (m_mode == 3) begin
                m_ps = 1; m_addr = wr_addr; m_data = wr_data; m_mode = 0;
            end else if (m_mode == 2) begin
                if (c == 2) begin m_es = 1; m_addr = wr_addr; m_data = wr_data; end
                m_mode = 0;
            end else if (c == 0) m_mode = 0;
            else if (c == 1) m_mode = 1;
            else if (c == 2) m_mode = 2;
            else if (c == 3) m_mode = 3;
        end
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "read_ident", 32'(read_ident), 32'(m_mode == 1));
        chk(req, "prog_start", 32'(prog_start), 32'(m_ps));
        chk(req, "erase_start", 32'(erase_start), 32'(m_es));
        chk(req, "start_addr", 32'(start_addr), 32'(m_addr));
        chk(req, "start_data", 32'(start_data), 32'(m_data));
        chk(req, "id_data", 32'(id_data), 32'(exp_id(m_mode, id_addr_lsb)));
    endtask

    // called at a negative edge: drive, clock, update model, sample at next negedge
    task automatic cyc(input bit v, input logic [AW-1:0] a, input logic [7:0] d,
                       input bit en, input bit busy, input bit lsb, input string req);
        wr_valid = v; wr_addr = a; wr_data = d; prog_en = en; seq_busy = busy;
        id_addr_lsb = lsb;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(req);
    endtask

    task automatic wr(input logic [7:0] d, input string req);
        cyc(1, AW'(32'h1234 + d), d, 1, 0, d[0], req);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int r;
        r = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all("R1");
        rst_n = 1'b1;
        prog_en = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R3 / R4 identifier mode and codes
        wr(8'h90, "R3");
        cyc(0, '0, 8'h00, 1, 0, 1'b0, "R4");
        cyc(0, '0, 8'h00, 1, 0, 1'b1, "R4");
        // R10 unknown byte keeps identifier mode
        wr(8'h07, "R10");
        // R2 read command
        wr(8'h00, "R2");
        wr(8'h80, "R3");
        // R2 reset sequence
        wr(8'hFF, "R2");
        wr(8'hFF, "R2");
        // R5 / R11 erase
        wr(8'h30, "R5");
        cyc(1, AW'(32'h2ABCD), 8'h30, 1, 0, 0, "R5");
        cyc(0, '0, 8'h00, 1, 0, 0, "R11");
        // R6 program, data equal to a command code
        wr(8'h50, "R6");
        cyc(1, AW'(32'h3FFFF), 8'hA5, 1, 0, 0, "R6");
        wr(8'h10, "R6");
        cyc(1, AW'(32'h00001), 8'hFF, 1, 0, 0, "R6");
        // R7 mismatched confirm
        wr(8'h30, "R7");
        wr(8'h90, "R7");
        wr(8'h30, "R7");
        // R8 enable drops in the same cycle as the erase confirm
        cyc(1, AW'(32'h55), 8'h30, 0, 0, 0, "R8");
        wr(8'h30, "R8");
        wr(8'h00, "R8");
        // R8 writes ignored while unpowered, read mode after return
        wr(8'h90, "R8");
        cyc(1, '0, 8'h90, 0, 0, 0, "R8");
        cyc(0, '0, 8'h00, 1, 0, 1, "R8");
        // R9 busy during an erase confirm keeps the setup
        wr(8'h30, "R9");
        cyc(1, AW'(32'h77), 8'h30, 1, 1, 0, "R9");
        cyc(1, AW'(32'h78), 8'h30, 1, 0, 0, "R9");
        // R9 busy in identifier mode
        wr(8'h80, "R9");
        cyc(1, '0, 8'h00, 1, 1, 1, "R9");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] d;
            int pick;
            pick = int'($urandom_range(0, 8));
            case (pick)
                0: d = 8'h00; 1: d = 8'hFF; 2: d = 8'h80; 3: d = 8'h90;
                4, 5: d = 8'h30; 6: d = 8'h10; 7: d = 8'h50;
                default: d = 8'($urandom);
            endcase
            cyc($urandom_range(0, 3) != 0, AW'($urandom), d,
                $urandom_range(0, 15) != 0, $urandom_range(0, 7) == 0,
                1'($urandom), "R11");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule